// File: doc/BRIEF.md
# Predicated Register Execution Unit

This block is a small register-to-register execution stage in which every issued operation is guarded by a condition code. A compare operation stores three status flags. Every later operation first tests its own condition against those stored flags. If the test passes, the operation commits. If it fails, the operation still uses its issue slot but leaves no trace: no register write, no flag change and no redirect. The second source operand can be shifted left by an immediate amount before it reaches the adder. This allows a scaled add such as `d = a + (b << 4)`, which multiplies `b` by 16, in a single operation.

Decoded operations arrive on a valid strobe, one per cycle. Each operation carries an opcode, a condition, a destination, two source register indices and a shift amount. Results leave on a registered writeback port one cycle after issue. The unit also drives the current flags and a branch-taken pulse. A conditional branch operation produces only that pulse, so a loop such as the subtract-based greatest-common-divisor needs only its loop-closing branch. Its two reduction steps are predicated subtracts.

Top module: `predExecUnit`

## Requirements
- R1: While `rstN` is low, all registers read as zero, `wbValid` and `branchTaken` are low, and all three flags are low.
- R2: Opcode 0 (add) writes `srcA + (srcB << shamt)` to `dst`, and opcode 4 (load constant) writes the `srcB` index value, zero-extended and shifted left by `shamt`.
- R3: Opcode 1 (subtract) writes `srcA - (srcB << shamt)`, and opcode 2 (reverse subtract) writes `(srcB << shamt) - srcA`, both modulo 2^32.
- R4: Opcode 3 (compare) writes no register. It sets `flagEq` when `srcA` equals `srcB << shamt`, sets `flagGt` when `srcA` is greater in signed two's complement, and sets `flagLt` when `srcA` is less; at most one flag is ever high.
- R5: Conditions are tested against the flags stored before the operation: 0 always, 1 equal, 2 not-equal (`!flagEq`), 3 greater, 4 less, 5 less-or-equal, 6 greater-or-equal, 7 never.
- R6: An operation whose condition fails writes no register, changes no flag, raises neither `wbValid` nor `branchTaken`, and the next operation may issue in the following cycle.
- R7: Only a compare whose condition passes changes the flags; the flags reset to all low.
- R8: Opcode 5 (branch) writes no register and pulses `branchTaken` high for one cycle, in the cycle after issue, when its condition passes.
- R9: The shift amount ranges over 0 to 31; bits shifted beyond bit 31 are discarded.
- R10: A register written by an operation is read with its new value by an operation issued in the very next cycle.
- R11: `wbValid` is high, with `wbAddr` equal to `dst` and `wbData` equal to the result, in exactly the cycle after a writing operation (opcodes 0, 1, 2, 4) issues with a passing condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is presented this cycle |
| issueOp | input | 3 | Opcode |
| issueCond | input | 3 | Condition code |
| issueDst | input | 4 | Destination register index |
| issueSrcA | input | 4 | First source register index |
| issueSrcB | input | 4 | Second source register index (constant value for load) |
| issueShamt | input | 5 | Left-shift amount applied to the second operand |
| wbValid | output | 1 | Writeback strobe |
| wbAddr | output | 4 | Writeback register index |
| wbData | output | 32 | Writeback value |
| flagEq | output | 1 | Last compare found equal operands |
| flagGt | output | 1 | Last compare found first operand greater (signed) |
| flagLt | output | 1 | Last compare found first operand less (signed) |
| branchTaken | output | 1 | A branch operation passed its condition last cycle |

## Verification
The bench sweeps all eight conditions after compares that leave the operands equal, greater and less. A unit that reads the wrong flag would commit an add it should skip, and the accumulated register would then differ from the model. Shift amounts of 0, 4, 28 and 31 are included, so a shifter that keeps overflowed bits or truncates the shift field yields a wrong sum. A compare that is itself predicated false, and a negative operand compared signed, both target flag logic that updates too eagerly or compares unsigned. The GCD loop issues dependent operations back to back under changing flags. A unit with a stale register read or a misplaced branch pulse would end on the wrong divisor or loop for the wrong number of iterations.

// File: rtl/predExecPkg.sv
package predExecPkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_RSB  = 3'd2,
    OP_CMP  = 3'd3,
    OP_MOVI = 3'd4,
    OP_BR   = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opCode_e;

  typedef enum logic [2:0] {
    CC_AL = 3'd0,
    CC_EQ = 3'd1,
    CC_NE = 3'd2,
    CC_GT = 3'd3,
    CC_LT = 3'd4,
    CC_LE = 3'd5,
    CC_GE = 3'd6,
    CC_NV = 3'd7
  } condCode_e;

  localparam int COND_COUNT = 8;

  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } flags_t;

  typedef enum logic [1:0] {
    SEL_ADD = 2'd0,
    SEL_SUB = 2'd1,
    SEL_RSB = 2'd2,
    SEL_IMM = 2'd3
  } aluSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    regWe;
    aluSel_e aluSel;
  } strobes_t;

  function automatic logic condHolds(input condCode_e cc, input flags_t f);
    logic r;
    unique case (cc)
      CC_AL:   r = 1'b1;
      CC_EQ:   r = f.eq;
      CC_NE:   r = !f.eq;
      CC_GT:   r = f.gt;
      CC_LT:   r = f.lt;
      CC_LE:   r = f.eq || f.lt;
      CC_GE:   r = f.eq || f.gt;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/predCtrl.sv
module predCtrl
  import predExecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic [2:0] issueOp,
  input  logic [2:0] issueCond,
  input  flags_t     cmpRes,
  output strobes_t   strb,
  output flags_t     flags,
  output logic       branchTaken
);

  logic [COND_COUNT-1:0] condTable;
  logic                  condPass;
  logic                  flagWe;
  logic                  brNext;
  opCode_e               op;

  // one evaluator per condition code, selected by the issued code
  generate
    for (genvar c = 0; c < COND_COUNT; c++) begin : g_cond
      assign condTable[c] = condHolds(condCode_e'(3'(c)), flags);
    end
  endgenerate

  assign op       = opCode_e'(issueOp);
  assign condPass = issueValid && condTable[issueCond];
  assign flagWe   = condPass && (op == OP_CMP);
  assign brNext   = condPass && (op == OP_BR);

  always_comb begin
    strb.regWe  = 1'b0;
    strb.aluSel = SEL_ADD;
    unique case (op)
      OP_ADD:  begin strb.regWe = condPass; strb.aluSel = SEL_ADD; end
      OP_SUB:  begin strb.regWe = condPass; strb.aluSel = SEL_SUB; end
      OP_RSB:  begin strb.regWe = condPass; strb.aluSel = SEL_RSB; end
      OP_MOVI: begin strb.regWe = condPass; strb.aluSel = SEL_IMM; end
      default: begin strb.regWe = 1'b0;     strb.aluSel = SEL_ADD; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags       <= '0;
      branchTaken <= 1'b0;
    end else begin
      if (flagWe) flags <= cmpRes;
      branchTaken <= brNext;
    end
  end

  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flags.eq, flags.gt, flags.lt}));

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(issueValid && issueOp == 3'(OP_CMP)) |=> $stable(flags));

  // R8
  branch_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> $past(issueValid && issueOp == 3'(OP_BR)));

endmodule

// File: rtl/predDatapath.sv
module predDatapath
  import predExecPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 16,
  localparam int ADDR_W = $clog2(REG_N),
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] srcA,
  input  logic [ADDR_W-1:0] srcB,
  input  logic [ADDR_W-1:0] dst,
  input  logic [SH_W-1:0]   shamt,
  output flags_t            cmpRes,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);

  logic [DATA_W-1:0] rdVec [REG_N];
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] shB;
  logic [DATA_W-1:0] immVal;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] result;

  // register file: one storage word per generate slot
  generate
    for (genvar r = 0; r < REG_N; r++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strb.regWe && dst == ADDR_W'(r)) q <= result;
      end
      assign rdVec[r] = q;
    end
  endgenerate

  assign opA    = rdVec[srcA];
  assign opB    = rdVec[srcB];
  assign shB    = opB << shamt;
  assign immVal = DATA_W'(srcB) << shamt;

  always_comb begin
    unique case (strb.aluSel)
      SEL_ADD: result = opA + shB;
      SEL_SUB: result = opA - shB;
      SEL_RSB: result = shB - opA;
      default: result = immVal;
    endcase
  end

  // compare by subtraction; sign decided on two's complement operands
  assign diff      = opA - shB;
  assign cmpRes.eq = (diff == '0);
  assign cmpRes.lt = $signed(opA) < $signed(shB);
  assign cmpRes.gt = !cmpRes.eq && !cmpRes.lt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbAddr  <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strb.regWe;
      if (strb.regWe) begin
        wbAddr <= dst;
        wbData <= result;
      end
    end
  end

endmodule

// File: rtl/predExecUnit.sv
module predExecUnit
  import predExecPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 16,
  localparam int ADDR_W = $clog2(REG_N),
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        issueOp,
  input  logic [2:0]        issueCond,
  input  logic [ADDR_W-1:0] issueDst,
  input  logic [ADDR_W-1:0] issueSrcA,
  input  logic [ADDR_W-1:0] issueSrcB,
  input  logic [SH_W-1:0]   issueShamt,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              flagEq,
  output logic              flagGt,
  output logic              flagLt,
  output logic              branchTaken
);

  strobes_t strb;
  flags_t   cmpRes;
  flags_t   flags;

  predCtrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .issueCond  (issueCond),
    .cmpRes     (cmpRes),
    .strb       (strb),
    .flags      (flags),
    .branchTaken(branchTaken)
  );

  predDatapath #(.DATA_W(DATA_W), .REG_N(REG_N)) dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .srcA   (issueSrcA),
    .srcB   (issueSrcB),
    .dst    (issueDst),
    .shamt  (issueShamt),
    .cmpRes (cmpRes),
    .wbValid(wbValid),
    .wbAddr (wbAddr),
    .wbData (wbData)
  );

  assign flagEq = flags.eq;
  assign flagGt = flags.gt;
  assign flagLt = flags.lt;

  // R11
  wb_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(issueValid && (issueOp == 3'(OP_ADD) || issueOp == 3'(OP_SUB) ||
                                     issueOp == 3'(OP_RSB) || issueOp == 3'(OP_MOVI))));

  // R6
  never_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCond == 3'(CC_NV)) |=>
      (!wbValid && !branchTaken && $stable(flagEq) && $stable(flagGt) && $stable(flagLt)));

endmodule

// File: tb/predExecUnit_test.sv
`timescale 1ns/1ps
module predExecUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iValid = 1'b0;
  logic [2:0]  iOp = '0;
  logic [2:0]  iCond = '0;
  logic [3:0]  iDst = '0, iA = '0, iB = '0;
  logic [4:0]  iSh = '0;
  logic        wbValid;
  logic [3:0]  wbAddr;
  logic [31:0] wbData;
  logic        flagEq, flagGt, flagLt, branchTaken;

  predExecUnit uut (
    .clk(clk), .rstN(rstN), .issueValid(iValid), .issueOp(iOp), .issueCond(iCond),
    .issueDst(iDst), .issueSrcA(iA), .issueSrcB(iB), .issueShamt(iSh),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .flagEq(flagEq), .flagGt(flagGt), .flagLt(flagLt), .branchTaken(branchTaken)
  );

  always #2.5 clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  logic [31:0] mReg [16];
  logic        mEq = 0, mGt = 0, mLt = 0;
  logic        eValid = 0, eBr = 0;
  logic [3:0]  eAddr = '0;
  logic [31:0] eData = '0;
  string       vTag = "R1", dTag = "R1", fTag = "R1", bTag = "R1";
  logic [31:0] ma, mb, mr;
  bit          mOk;

  function automatic bit holds(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return mEq;
      3'd2: return !mEq;
      3'd3: return mGt;
      3'd4: return mLt;
      3'd5: return mEq || mLt;
      3'd6: return mEq || mGt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mReg[i] = '0;
      mEq = 0; mGt = 0; mLt = 0;
      eValid = 0; eBr = 0;
      vTag = "R1"; dTag = "R1"; fTag = "R1"; bTag = "R1";
    end else begin
      eValid = 0; eBr = 0;
      vTag = "R11"; fTag = "R7"; bTag = "R8";
      if (iValid) begin
        mOk = holds(iCond);
        ma  = mReg[iA];
        mb  = mReg[iB] << iSh;
        if (iCond != 3'd0) vTag = mOk ? "R5" : "R6";
        if (!mOk) begin fTag = "R6"; bTag = "R6"; end
        mr = '0;
        case (iOp)
          3'd0: begin mr = ma + mb; dTag = (iSh != 0) ? "R9" : "R2"; end
          3'd1: begin mr = ma - mb; dTag = "R3"; end
          3'd2: begin mr = mb - ma; dTag = "R3"; end
          3'd4: begin mr = 32'(iB) << iSh; dTag = "R2"; end
          default: ;
        endcase
        if (mOk) begin
          case (iOp)
            3'd0, 3'd1, 3'd2, 3'd4: begin
              eValid = 1; eAddr = iDst; eData = mr; mReg[iDst] = mr;
            end
            3'd3: begin
              mEq = (ma == mb);
              mGt = $signed(ma) > $signed(mb);
              mLt = $signed(ma) < $signed(mb);
              fTag = "R4";
            end
            3'd5: eBr = 1;
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(wbValid === eValid, vTag, 32'(wbValid), 32'(eValid));
      if (eValid) begin
        chk(wbAddr === eAddr, "R11", 32'(wbAddr), 32'(eAddr));
        chk(wbData === eData, dTag, wbData, eData);
      end
      chk({flagEq, flagGt, flagLt} === {mEq, mGt, mLt}, fTag,
          32'({flagEq, flagGt, flagLt}), 32'({mEq, mGt, mLt}));
      chk(branchTaken === eBr, bTag, 32'(branchTaken), 32'(eBr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input int op, input int cond, input int d, input int a, input int b, input int sh);
    @(negedge clk);
    iValid = 1; iOp = 3'(op); iCond = 3'(cond);
    iDst = 4'(d); iA = 4'(a); iB = 4'(b); iSh = 5'(sh);
  endtask

  task automatic idle();
    @(negedge clk);
    iValid = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [31:0] lf;
    int iter;
    lf = 32'h1ACEB00C;
    repeat (3) @(negedge clk);      // R1 reset state checked here
    rstN = 1;

    // R2 constants
    issue(4, 0, 1, 0, 3, 2);        // r1 = 12
    issue(4, 0, 2, 0, 1, 3);        // r2 = 8
    issue(4, 0, 3, 0, 15, 28);      // r3 = 0xF0000000
    issue(4, 0, 4, 0, 5, 0);        // r4 = 5
    // R9 R10 scaled adds, back to back dependency
    issue(0, 0, 5, 1, 2, 4);        // 12 + 128
    issue(0, 0, 6, 4, 4, 31);
    issue(0, 0, 7, 3, 3, 4);
    issue(0, 0, 7, 7, 5, 0);
    // R3
    issue(1, 0, 8, 2, 1, 0);        // 8 - 12 negative
    issue(2, 0, 9, 2, 1, 1);        // 24 - 8
    // R5 condition sweep under greater, less, equal
    issue(3, 0, 0, 1, 2, 0);
    for (int c = 0; c < 8; c++) issue(0, c, 10, 10, 4, 0);
    issue(3, 0, 0, 2, 1, 0);
    for (int c = 0; c < 8; c++) issue(0, c, 10, 10, 4, 0);
    issue(3, 0, 0, 4, 4, 0);
    for (int c = 0; c < 8; c++) issue(0, c, 10, 10, 4, 0);
    // R4 signed compare of a negative value
    issue(3, 0, 0, 8, 1, 0);
    // R6 R7 compare predicated false keeps flags
    issue(3, 3, 0, 1, 2, 0);
    issue(3, 7, 0, 1, 1, 0);
    // R8 branches
    for (int c = 0; c < 8; c++) issue(5, c, 0, 0, 0, 0);
    idle();

    // GCD loop: compare, subtract on greater, reverse subtract on less-or-equal, branch on not-equal
    issue(4, 0, 11, 0, 3, 2);       // 12
    issue(4, 0, 12, 0, 1, 3);       // 8
    iter = 0;
    do begin
      issue(3, 0, 0, 11, 12, 0);
      issue(1, 3, 11, 11, 12, 0);
      issue(2, 5, 12, 11, 12, 0);
      issue(5, 2, 0, 0, 0, 0);
      idle();
      iter++;
    end while (eBr && iter < 20);
    issue(0, 0, 13, 11, 0, 0);      // expose the divisor
    idle();

    // mixed pattern
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(int'(lf[2:0]) % 6, int'(lf[5:3]), int'(lf[9:6]), int'(lf[13:10]),
            int'(lf[17:14]), lf[18] ? int'(lf[23:19]) : 0);
    end
    idle();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule